// File: doc/BRIEF.md
# Status Register Interrupt and Trap Controller

This block keeps the processor's status word and decides when an interrupt is taken. The status word holds the following fields:

- a current-supervisor flag
- a previous-supervisor flag
- a global trap-enable flag
- two 64-bit mode flags
- an eight-bit interrupt mask
- an eight-bit pending field

Each pending bit is raised or lowered by hardware, never by a plain status write. An interrupt is requested when a pending bit whose mask bit is set exists and traps are enabled. The winning source is the lowest-numbered one, and its cause code is presented to the core.

A free-running 32-bit retire counter advances by the number of instructions retired each cycle, from 0 to 4. A compare register raises the timer pending bit when the counter steps onto or over the compare value.

A trap-entry strobe from the core performs the mode switch: supervisor on, previous mode saved, traps off. Software reaches every register through a single write/read port. Other units raise or lower any pending bit by index through a set/clear line.

The pending field has three fixed sources:

| Source | Index |
|---|---|
| Inter-processor | 5 |
| Host | 6 |
| Timer | 7 |

Top module: `sr_trap_ctl`

## Requirements
- R1: `irq_req` is high exactly when (pending AND mask) is nonzero and the trap-enable bit is 1.
- R2: When several masked pending bits are set, the lowest index wins.
- R3: `irq_cause` reads 0x8000_0000_0000_000i when index i wins, and 0 when there is no request. The same value reads back at register address 5.
- R4: A `trap_take` pulse makes the following changes:
    - It sets the supervisor bit (bit 0).
    - It copies the old supervisor bit into the previous-supervisor bit (bit 1).
    - It clears trap-enable (bit 2).
    - If a status write arrives in the same cycle, the write is ignored.
- R5: A write to status (address 0) loads the following fields from the written value, and the pending field keeps its value:
    - supervisor (bit 0), previous-supervisor (bit 1) and trap-enable (bit 2)
    - 64-bit supervisor mode (bit 3) and 64-bit user mode (bit 4)
    - mask [15:8]
    - The pending field [23:16] is not written. All other bits read 0.
- R6: A write to compare (address 2) clears pending bit 7, unless a timer crossing happens in that same cycle.
- R7: Pending bit 7 is set when the old count is below compare and old count plus the retire increment is greater than or equal to compare. The sum is computed 33 bits wide, so a crossing is still seen when the count wraps.
- R8: A write to the inter-processor register (address 3) sets pending bit 5 to written bit 0. A write to the host register (address 4) sets pending bit 6 when the value is nonzero and clears it when the value is zero. Both registers read back their pending bit in bit 0.
- R9: An `ext_irq_we` pulse sets pending bit `ext_irq_idx` to `ext_irq_val`. An index of 8 or above changes nothing. In the same cycle, register writes and a timer crossing take precedence over the line.
- R10: After reset, status reads 0x0000_FF09: supervisor set, 64-bit supervisor mode set, all mask bits set, trap-enable off, nothing pending. Count and compare read 0.
- R11: The count (address 1) adds `retire_cnt` every cycle and wraps at 32 bits. A count write in the same cycle loads the written value instead, and that cycle raises no timer crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register select: 0 status, 1 count, 2 compare, 3 inter-processor, 4 host, 5 cause |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Combinational read data for `csr_addr` |
| ext_irq_we | input | 1 | Pending-line strobe |
| ext_irq_idx | input | 4 | Pending bit index; 8 to 15 are ignored |
| ext_irq_val | input | 1 | New value for the indexed pending bit |
| retire_cnt | input | 3 | Instructions retired this cycle, 0 to 4 |
| trap_take | input | 1 | Trap-entry strobe |
| irq_req | output | 1 | Interrupt request |
| irq_cause | output | 64 | Cause code of the winning interrupt |

## Verification
The bench fills the pending field with every one of the 256 patterns. For each pattern it sweeps the mask and checks the request and the cause, so a priority encoder that favours high indices, or that ignores the mask or trap-enable, fails at once.

The timer is driven into three cases:
- a count landing exactly on compare, which a strict greater-than test would miss
- a count starting equal to compare, which a sloppy test would fire on
- a sum that wraps past 2^32, which a 32-bit sum would miss

Status writes of all ones and of zeros catch a design that lets software overwrite pending bits. Trap entry from both privilege levels, and a write colliding with trap entry, catch a wrong previous-mode save or the wrong precedence.

// File: rtl/sr_ctl_pkg.sv
package sr_ctl_pkg;
    localparam int XLEN   = 64;
    localparam int NSRC   = 8;
    localparam int SRCW   = $clog2(NSRC);
    localparam int CNTW   = 32;
    localparam int RETW   = 3;

    // status word field positions
    localparam int ST_SUP  = 0;
    localparam int ST_PSUP = 1;
    localparam int ST_TEN  = 2;
    localparam int ST_S64  = 3;
    localparam int ST_U64  = 4;
    localparam int ST_MASK = 8;
    localparam int ST_PEND = 16;

    // fixed pending sources
    localparam int SRC_IPI   = 5;
    localparam int SRC_HOST  = 6;
    localparam int SRC_TIMER = 7;

    typedef enum logic [2:0] {
        REG_STATUS  = 3'd0,
        REG_COUNT   = 3'd1,
        REG_COMPARE = 3'd2,
        REG_IPI     = 3'd3,
        REG_HOST    = 3'd4,
        REG_CAUSE   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/sr_status_reg.sv
module sr_status_reg
    import sr_ctl_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic          trap_take,
    output logic          sup,
    output logic          prev_sup,
    output logic          trap_en,
    output logic          s64,
    output logic          u64,
    output logic [NS-1:0] mask
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup      <= 1'b1;
            prev_sup <= 1'b0;
            trap_en  <= 1'b0;
            s64      <= 1'b1;
            u64      <= 1'b0;
            mask     <= '1;
        end else if (trap_take) begin
            sup      <= 1'b1;
            prev_sup <= sup;
            trap_en  <= 1'b0;
        end else if (wr_en) begin
            sup      <= wdata[ST_SUP];
            prev_sup <= wdata[ST_PSUP];
            trap_en  <= wdata[ST_TEN];
            s64      <= wdata[ST_S64];
            u64      <= wdata[ST_U64];
            mask     <= wdata[ST_MASK +: NS];
        end
    end

    assert_trap_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (sup && !trap_en && (prev_sup == $past(sup))));
endmodule

// File: rtl/sr_pending.sv
module sr_pending
    import sr_ctl_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int IW = SRCW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_idx,
    input  logic          ext_val,
    input  logic          ipi_we,
    input  logic          ipi_val,
    input  logic          host_we,
    input  logic          host_val,
    input  logic          cmp_we,
    input  logic          timer_hit,
    output logic [NS-1:0] pend
);
    logic [NS-1:0] pend_d;

    always_comb begin
        pend_d = pend;
        for (int i = 0; i < NS; i++) begin
            if (ext_we && (ext_idx == IW'(i))) pend_d[i] = ext_val;
            if (i == SRC_IPI && ipi_we)        pend_d[i] = ipi_val;
            if (i == SRC_HOST && host_we)      pend_d[i] = host_val;
            if (i == SRC_TIMER) begin
                if (cmp_we)    pend_d[i] = 1'b0;
                if (timer_hit) pend_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_d;
    end

    assert_cmp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !timer_hit) |=> !pend[SRC_TIMER]);

    assert_idx_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && ext_idx >= IW'(NS) && !ipi_we && !host_we && !cmp_we && !timer_hit)
        |=> $stable(pend));
endmodule

// File: rtl/sr_timer.sv
module sr_timer
    import sr_ctl_pkg::*;
#(
    parameter int CW = CNTW,
    parameter int RW = RETW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_we,
    input  logic          cmp_we,
    input  logic [CW-1:0] wdata,
    input  logic [RW-1:0] retire,
    output logic [CW-1:0] count,
    output logic [CW-1:0] compare,
    output logic          hit
);
    logic [CW:0] sum;

    assign sum = {1'b0, count} + {{(CW+1-RW){1'b0}}, retire};
    assign hit = !cnt_we && (count < compare) && (sum >= {1'b0, compare});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            compare <= '0;
        end else begin
            count <= cnt_we ? wdata : sum[CW-1:0];
            if (cmp_we) compare <= wdata;
        end
    end

    assert_count_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count == $past(wdata)));
endmodule

// File: rtl/sr_irq_arb.sv
module sr_irq_arb
    import sr_ctl_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int W  = XLEN,
    parameter int IW = SRCW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] pend,
    input  logic [NS-1:0] mask,
    input  logic          trap_en,
    output logic          req,
    output logic [W-1:0]  cause
);
    logic [NS-1:0] act;
    logic [NS:0]   none_below;
    logic [NS-1:0] grant;
    logic [IW-1:0] idx;

    assign act           = pend & mask;
    assign none_below[0] = 1'b1;

    for (genvar i = 0; i < NS; i++) begin : g_chain
        assign grant[i]        = act[i] & none_below[i];
        assign none_below[i+1] = none_below[i] & ~act[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NS; i++)
            if (grant[i]) idx = IW'(i);
    end

    assign req   = trap_en && !none_below[NS];
    assign cause = req ? {1'b1, {(W-1-IW){1'b0}}, idx} : '0;

    assert_req_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (trap_en && (pend & mask) != '0));

    assert_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (pend[cause[IW-1:0]] && mask[cause[IW-1:0]] &&
                 ((pend & mask & ~({NS{1'b1}} << cause[IW-1:0])) == '0)));
endmodule

// File: rtl/sr_trap_ctl.sv
module sr_trap_ctl
    import sr_ctl_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int NS = NSRC,
    parameter int CW = CNTW,
    parameter int RW = RETW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [2:0]    csr_addr,
    input  logic [W-1:0]  csr_wdata,
    output logic [W-1:0]  csr_rdata,
    input  logic          ext_irq_we,
    input  logic [3:0]    ext_irq_idx,
    input  logic          ext_irq_val,
    input  logic [RW-1:0] retire_cnt,
    input  logic          trap_take,
    output logic          irq_req,
    output logic [W-1:0]  irq_cause
);
    localparam int IW = $clog2(NS);

    logic st_we, cnt_we, cmp_we, ipi_we, host_we;
    logic sup, prev_sup, trap_en, s64, u64;
    logic [NS-1:0] mask, pend;
    logic [CW-1:0] count, compare;
    logic timer_hit;
    logic [W-1:0] status_word;

    always_comb begin
        st_we   = 1'b0;
        cnt_we  = 1'b0;
        cmp_we  = 1'b0;
        ipi_we  = 1'b0;
        host_we = 1'b0;
        if (csr_we) begin
            unique case (reg_sel_e'(csr_addr))
                REG_STATUS:  st_we   = 1'b1;
                REG_COUNT:   cnt_we  = 1'b1;
                REG_COMPARE: cmp_we  = 1'b1;
                REG_IPI:     ipi_we  = 1'b1;
                REG_HOST:    host_we = 1'b1;
                default:     ;
            endcase
        end
    end

    sr_status_reg #(.W(W), .NS(NS)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(st_we), .wdata(csr_wdata),
        .trap_take(trap_take), .sup(sup), .prev_sup(prev_sup),
        .trap_en(trap_en), .s64(s64), .u64(u64), .mask(mask)
    );

    sr_timer #(.CW(CW), .RW(RW)) u_timer (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cmp_we(cmp_we),
        .wdata(csr_wdata[CW-1:0]), .retire(retire_cnt),
        .count(count), .compare(compare), .hit(timer_hit)
    );

    sr_pending #(.NS(NS), .IW(IW + 1)) u_pend (
        .clk(clk), .rst_n(rst_n), .ext_we(ext_irq_we),
        .ext_idx(ext_irq_idx[IW:0]), .ext_val(ext_irq_val),
        .ipi_we(ipi_we), .ipi_val(csr_wdata[0]),
        .host_we(host_we), .host_val(|csr_wdata),
        .cmp_we(cmp_we), .timer_hit(timer_hit), .pend(pend)
    );

    sr_irq_arb #(.NS(NS), .W(W), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask),
        .trap_en(trap_en), .req(irq_req), .cause(irq_cause)
    );

    always_comb begin
        status_word              = '0;
        status_word[ST_SUP]      = sup;
        status_word[ST_PSUP]     = prev_sup;
        status_word[ST_TEN]      = trap_en;
        status_word[ST_S64]      = s64;
        status_word[ST_U64]      = u64;
        status_word[ST_MASK+:NS] = mask;
        status_word[ST_PEND+:NS] = pend;
    end

    always_comb begin
        unique case (reg_sel_e'(csr_addr))
            REG_STATUS:  csr_rdata = status_word;
            REG_COUNT:   csr_rdata = W'(count);
            REG_COMPARE: csr_rdata = W'(compare);
            REG_IPI:     csr_rdata = W'(pend[SRC_IPI]);
            REG_HOST:    csr_rdata = W'(pend[SRC_HOST]);
            REG_CAUSE:   csr_rdata = irq_cause;
            default:     csr_rdata = '0;
        endcase
    end

    assert_timer_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_hit |=> pend[SRC_TIMER]);

    assert_ipi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_we |=> (pend[SRC_IPI] == $past(csr_wdata[0])));

    assert_pend_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !ext_irq_we && !timer_hit) |=> $stable(pend));
endmodule

// File: tb/sr_trap_ctl_tb_top.sv
module sr_trap_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_addr = 3'd0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        ext_irq_we = 1'b0;
    logic [3:0]  ext_irq_idx = 4'd0;
    logic        ext_irq_val = 1'b0;
    logic [2:0]  retire_cnt = 3'd0;
    logic        trap_take = 1'b0;
    logic        irq_req;
    logic [63:0] irq_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sr_trap_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .ext_irq_we(ext_irq_we), .ext_irq_idx(ext_irq_idx),
        .ext_irq_val(ext_irq_val), .retire_cnt(retire_cnt),
        .trap_take(trap_take), .irq_req(irq_req), .irq_cause(irq_cause)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(logic [2:0] a, logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [63:0] d);
        csr_addr = a;
        #0.5;
        d = csr_rdata;
    endtask

    task automatic ext(logic [3:0] i, logic v);
        @(negedge clk);
        ext_irq_we = 1'b1; ext_irq_idx = i; ext_irq_val = v;
        @(negedge clk);
        ext_irq_we = 1'b0;
    endtask

    task automatic retire(logic [2:0] n);
        @(negedge clk);
        retire_cnt = n;
        @(negedge clk);
        retire_cnt = 3'd0;
    endtask

    task automatic trap(bit with_wr, logic [63:0] d);
        @(negedge clk);
        trap_take = 1'b1;
        if (with_wr) begin csr_we = 1'b1; csr_addr = 3'd0; csr_wdata = d; end
        @(negedge clk);
        trap_take = 1'b0; csr_we = 1'b0;
    endtask

    function automatic logic [63:0] stw(bit s, bit ps, bit et, bit s64, bit u64,
                                        logic [7:0] im, logic [7:0] ip);
        return {40'd0, ip, im, 3'd0, u64, s64, et, ps, s};
    endfunction

    function automatic logic [63:0] exp_cause(logic [7:0] act);
        for (int i = 0; i < 8; i++)
            if (act[i]) return 64'h8000_0000_0000_0000 | 64'(i);
        return 64'd0;
    endfunction

    task automatic timer_bit(string req, bit exp);
        logic [63:0] d;
        rd(3'd0, d);
        check(req, 64'(d[23]), 64'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(3'd0, d); check("R10 status", d, 64'h0000_FF09);
        rd(3'd1, d); check("R10 count", d, 0);
        rd(3'd2, d); check("R10 compare", d, 0);
        check("R10 req", 64'(irq_req), 0);
        check("R3 cause idle", irq_cause, 0);

        // R9 index range
        ext(4'd8, 1'b1);
        ext(4'd15, 1'b1);
        rd(3'd0, d); check("R9 idx>=8 ignored", d, 64'h0000_FF09);
        ext(4'd3, 1'b1);
        rd(3'd0, d); check("R9 set idx3", d, stw(1,0,0,1,0,8'hFF,8'h08));
        ext(4'd3, 1'b0);
        rd(3'd0, d); check("R9 clear idx3", d, 64'h0000_FF09);

        // R5 pending field protected
        ext(4'd2, 1'b1);
        csr_wr(3'd0, '1);
        rd(3'd0, d); check("R5 write ones", d, stw(1,1,1,1,1,8'hFF,8'h04));
        csr_wr(3'd0, '0);
        rd(3'd0, d); check("R5 write zeros", d, stw(0,0,0,0,0,8'h00,8'h04));
        ext(4'd2, 1'b0);

        // R1 R2 R3 sweep
        for (int p = 0; p < 256; p++) begin
            for (int b = 0; b < 8; b++) ext(4'(b), p[b]);
            for (int m = 0; m < 256; m += 3) begin
                csr_wr(3'd0, stw(0,0,1,0,0,8'(m),8'h00));
                check("R1 req", 64'(irq_req), 64'(((p & m) != 0) ? 1 : 0));
                check("R2 R3 cause", irq_cause, exp_cause(8'(p & m)));
            end
            csr_wr(3'd0, stw(0,0,0,0,0,8'hFF,8'h00));
            check("R1 trap-enable off", 64'(irq_req), 0);
        end
        for (int b = 0; b < 8; b++) ext(4'(b), 1'b0);
        ext(4'd6, 1'b1); ext(4'd4, 1'b1);
        csr_wr(3'd0, stw(0,0,1,0,0,8'hFF,8'h00));
        rd(3'd5, d); check("R3 cause readback", d, 64'h8000_0000_0000_0004);
        ext(4'd6, 1'b0); ext(4'd4, 1'b0);

        // R4 trap entry
        csr_wr(3'd0, stw(0,0,1,0,0,8'h00,8'h00));
        trap(0, '0);
        rd(3'd0, d); check("R4 trap from user", d, stw(1,0,0,0,0,8'h00,8'h00));
        trap(0, '0);
        rd(3'd0, d); check("R4 trap from super", d, stw(1,1,0,0,0,8'h00,8'h00));
        trap(1, stw(0,0,1,1,1,8'hAA,8'h00));
        rd(3'd0, d); check("R4 trap beats write", d, stw(1,1,0,0,0,8'h00,8'h00));

        // R11 counter
        csr_wr(3'd1, 64'd100);
        retire(3'd3);
        rd(3'd1, d); check("R11 add 3", d, 103);
        retire(3'd0);
        rd(3'd1, d); check("R11 add 0", d, 103);
        retire(3'd4);
        rd(3'd1, d); check("R11 add 4", d, 107);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 3'd1; csr_wdata = 64'd500; retire_cnt = 3'd4;
        @(negedge clk);
        csr_we = 1'b0; retire_cnt = 3'd0;
        rd(3'd1, d); check("R11 write beats retire", d, 500);
        csr_wr(3'd1, 64'hFFFF_FFFF);
        retire(3'd2);
        rd(3'd1, d); check("R11 wrap", d, 1);

        // R7 R6 timer
        csr_wr(3'd2, 64'd10);
        csr_wr(3'd1, 64'd0);
        retire(3'd4); retire(3'd4);
        timer_bit("R7 below compare", 0);
        retire(3'd4);
        timer_bit("R7 crossing", 1);
        csr_wr(3'd2, 64'd20);
        timer_bit("R6 compare write clears", 0);
        csr_wr(3'd1, 64'd16);
        retire(3'd4);
        timer_bit("R7 exact hit", 1);
        csr_wr(3'd2, 64'd30);
        csr_wr(3'd1, 64'd30);
        retire(3'd4);
        timer_bit("R7 old equal no fire", 0);
        csr_wr(3'd1, 64'd29);
        retire(3'd0);
        timer_bit("R7 zero increment", 0);
        csr_wr(3'd2, 64'hFFFF_FFFF);
        csr_wr(3'd1, 64'hFFFF_FFFE);
        retire(3'd4);
        timer_bit("R7 wrap crossing", 1);
        rd(3'd1, d); check("R11 wrapped count", d, 2);

        // R8 inter-processor and host
        csr_wr(3'd3, 64'd1);
        rd(3'd3, d); check("R8 ipi set", d, 1);
        csr_wr(3'd4, 64'h100);
        rd(3'd4, d); check("R8 host nonzero", d, 1);
        csr_wr(3'd0, stw(1,0,1,1,0,8'hFF,8'h00));
        check("R2 builtin lowest", irq_cause, 64'h8000_0000_0000_0005);
        csr_wr(3'd3, 64'd2);
        rd(3'd3, d); check("R8 ipi bit0 clear", d, 0);
        check("R2 next source", irq_cause, 64'h8000_0000_0000_0006);
        csr_wr(3'd4, 64'd0);
        rd(3'd4, d); check("R8 host zero", d, 0);
        check("R2 timer left", irq_cause, 64'h8000_0000_0000_0007);

        finish_run();
    end
endmodule